// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block watches the instruction fetch address of a processor and raises a breakpoint request when a fetch lands on a halfword that a debugger has marked. It holds one global control register and a parameterised bank of word-address comparators. Each comparator either requests a break on the lower halfword, the upper halfword or either halfword of its word, or reports a remap hit so that neighbouring logic can substitute the fetched data.

A debugger reaches the registers through a 32-bit register port: select 0 is the control register and select k (1 to NUM_COMP) is comparator k-1. Writes take effect on the next clock edge. Read data is combinational from the select. The fetch side is combinational: the outputs describe the fetch presented in the same cycle. The design has no state machine. Its only state is the registers.

Top module: `bp_unit`

## Requirements
- R1: After reset the global enable is 0, every comparator register reads 0, and brk_req and remap_hit are 0.
- R2: A write to select 0 updates the global enable from write-data bit 0 only when write-data bit 1 is 1. Otherwise the write has no effect.
- R3: Select 0 reads the global enable in bit 0, NUM_COMP[3:0] in bits 7:4 and NUM_COMP[6:4] in bits 14:12. Every other bit reads 0, including the key bit 1, literal count bits 11:8 and revision bits 31:28. Writes cannot change the count or revision fields.
- R4: Select k (1..NUM_COMP) stores and reads back all 32 bits written. A select above NUM_COMP reads 0 and ignores writes.
- R5: Comparator k matches when fetch_valid is 1, the global enable is 1, comparator bit 0 is 1 and fetch_addr[28:2] equals comparator bits 28:2.
- R6: The replace field is comparator bits 31:30. On a matching fetch, 01 raises brk_req when fetch_addr[1]=0, 10 raises it when fetch_addr[1]=1, and 11 raises it for either halfword. brk_req is asserted in the same cycle as the fetch.
- R7: A matching comparator whose replace field is 00 raises no break. It sets remap_hit, and remap_idx gives the lowest 0-based index among such comparators.
- R8: When the global enable is 0, when the comparator is disabled, or when fetch_valid is 0, brk_req and remap_hit stay 0.
- R9: A fetch with any of fetch_addr[31:29] nonzero never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | SEL_W | Register select: 0 control, k comparator k-1 |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | 31 | Fetch halfword address, bits 31:1 |
| brk_req | output | 1 | Breakpoint request for this fetch |
| remap_hit | output | 1 | A remap comparator matched |
| remap_idx | output | IDX_W | Lowest matching remap comparator |

## Verification
The bench points several comparators at a small pool of word addresses, so that more than one comparator often matches the same fetch. This exposes a priority encoder that returns the highest index, or one that lets a break-type comparator mask a remap. Directed cases try the lower and upper halfword for each replace code. A swapped halfword sense would raise brk_req on the wrong half. Writes to control without the key and writes to an unmapped select are read back afterwards, which catches a missing key gate or a decode that aliases the comparators. Fetches with high address bits set and fetches with the enables cleared must produce no outputs, which catches a comparison that covers too few bits or leaves out an enable.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        REPL_REMAP = 2'b00,
        REPL_LO    = 2'b01,
        REPL_HI    = 2'b10,
        REPL_BOTH  = 2'b11
    } repl_e;

    localparam int WORD_W   = 32;
    localparam int KEY_BIT  = 1;
    localparam int EN_BIT   = 0;
    localparam int CNT_W    = 7;
endpackage

// File: rtl/bp_ctrl_reg.sv
module bp_ctrl_reg
    import bp_pkg::*;
#(
    parameter int NUM_COMP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic              en_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam logic [CNT_W-1:0] COUNT = CNT_W'(NUM_COMP);

    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en && wdata[KEY_BIT])
            en_q <= wdata[EN_BIT];
    end

    assign en_o = en_q;

    // revision | reserved | count high | literal count | count low | zero | key | enable
    assign rdata_o = {4'h0, 13'h0, COUNT[6:4], 4'h0, COUNT[3:0], 2'b00, 1'b0, en_q};
endmodule

// File: rtl/bp_comparator.sv
module bp_comparator
    import bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              glb_en,
    input  logic              fetch_valid,
    input  logic [31:1]       fetch_addr,
    output logic [WORD_W-1:0] rdata_o,
    output logic              brk_o,
    output logic              remap_o
);
    logic [WORD_W-1:0] cfg_q;
    logic              hit;
    repl_e             repl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wdata;
    end

    assign rdata_o = cfg_q;
    assign repl    = repl_e'(cfg_q[31:30]);
    assign hit     = fetch_valid && glb_en && cfg_q[EN_BIT]
                     && (fetch_addr[31:29] == 3'b000)
                     && (fetch_addr[28:2] == cfg_q[28:2]);

    always_comb begin
        brk_o   = 1'b0;
        remap_o = 1'b0;
        unique case (repl)
            REPL_REMAP: remap_o = hit;
            REPL_LO:    brk_o   = hit && !fetch_addr[1];
            REPL_HI:    brk_o   = hit &&  fetch_addr[1];
            REPL_BOTH:  brk_o   = hit;
        endcase
    end
endmodule

// File: rtl/bp_lowest_first.sv
module bp_lowest_first #(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/bp_unit.sv
module bp_unit
    import bp_pkg::*;
#(
    parameter int  NUM_COMP = 6,
    localparam int SEL_W    = $clog2(NUM_COMP + 1),
    localparam int IDX_W    = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [31:1]       fetch_addr,
    output logic              brk_req,
    output logic              remap_hit,
    output logic [IDX_W-1:0]  remap_idx
);
    logic              glb_en;
    logic [31:0]       ctrl_rd;
    logic [31:0]       cmp_rd [NUM_COMP];
    logic [NUM_COMP-1:0] cmp_we;
    logic [NUM_COMP-1:0] cmp_brk;
    logic [NUM_COMP-1:0] cmp_remap;

    bp_ctrl_reg #(.NUM_COMP(NUM_COMP)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wen && (reg_sel == '0)),
        .wdata   (reg_wdata),
        .en_o    (glb_en),
        .rdata_o (ctrl_rd)
    );

    for (genvar k = 0; k < NUM_COMP; k++) begin : g_cmp
        assign cmp_we[k] = reg_wen && (reg_sel == SEL_W'(k + 1));

        bp_comparator u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (cmp_we[k]),
            .wdata       (reg_wdata),
            .glb_en      (glb_en),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .rdata_o     (cmp_rd[k]),
            .brk_o       (cmp_brk[k]),
            .remap_o     (cmp_remap[k])
        );
    end

    bp_lowest_first #(.N(NUM_COMP), .IDX_W(IDX_W)) u_prio (
        .req   (cmp_remap),
        .any_o (remap_hit),
        .idx_o (remap_idx)
    );

    assign brk_req = |cmp_brk;

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == '0)
            reg_rdata = ctrl_rd;
        for (int k = 0; k < NUM_COMP; k++) begin
            if (reg_sel == SEL_W'(k + 1))
                reg_rdata = cmp_rd[k];
        end
    end
endmodule

// File: rtl/bp_unit_chk.sv
module bp_unit_chk #(
    parameter int NUM_COMP = 6,
    parameter int SEL_W    = 3,
    parameter int IDX_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] reg_sel,
    input logic             reg_wen,
    input logic [31:0]      reg_wdata,
    input logic             fetch_valid,
    input logic [31:1]      fetch_addr,
    input logic             brk_req,
    input logic             remap_hit,
    input logic [IDX_W-1:0] remap_idx,
    input logic             glb_en
);
    // R2: a control write without the key leaves the enable unchanged
    a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_sel == '0 && !reg_wdata[1]) |=> $stable(glb_en));

    // R2: a keyed control write loads the enable bit
    a_r2_key_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_sel == '0 && reg_wdata[1]) |=> (glb_en == $past(reg_wdata[0])));

    // R8: no break without a valid fetch and global enable
    a_r8_brk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (fetch_valid && glb_en));

    // R8: no remap hit without a valid fetch and global enable
    a_r8_remap_gated: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (fetch_valid && glb_en));

    // R9: high address region never matches
    a_r9_region: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr[31:29] != 3'b000) |-> (!brk_req && !remap_hit));

    // R7: reported index names an existing comparator
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (int'(remap_idx) < NUM_COMP));
endmodule

bind bp_unit bp_unit_chk #(.NUM_COMP(NUM_COMP), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_wen     (reg_wen),
    .reg_wdata   (reg_wdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .brk_req     (brk_req),
    .remap_hit   (remap_hit),
    .remap_idx   (remap_idx),
    .glb_en      (glb_en)
);

// File: tb/bp_unit_tb.sv
`timescale 1ns/1ps
module bp_unit_tb;
    localparam int N     = 6;
    localparam int SEL_W = $clog2(N + 1);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SEL_W-1:0] reg_sel = '0;
    logic             reg_wen = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             fetch_valid = 1'b0;
    logic [31:1]      fetch_addr = '0;
    logic             brk_req;
    logic             remap_hit;
    logic [IDX_W-1:0] remap_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        m_en;
    logic [31:0] m_cmp [N];

    always #2.5 clk = ~clk;

    bp_unit #(.NUM_COMP(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .brk_req(brk_req), .remap_hit(remap_hit),
        .remap_idx(remap_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_exp();
        logic [6:0] c = 7'(N);
        return {17'h0, c[6:4], 4'h0, c[3:0], 3'b000, m_en};
    endfunction

    function automatic logic cmp_match(int k, logic [31:1] a);
        return m_en && m_cmp[k][0] && a[31:29] == 3'b000 && a[28:2] == m_cmp[k][28:2];
    endfunction

    function automatic logic exp_brk(logic [31:1] a);
        logic r = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (cmp_match(k, a)) begin
                if (m_cmp[k][31:30] == 2'b11) r = 1'b1;
                if (m_cmp[k][31:30] == 2'b01 && !a[1]) r = 1'b1;
                if (m_cmp[k][31:30] == 2'b10 && a[1]) r = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic int exp_remap(logic [31:1] a);
        for (int k = 0; k < N; k++)
            if (cmp_match(k, a) && m_cmp[k][31:30] == 2'b00) return k;
        return -1;
    endfunction

    task automatic do_write(input int sel, input logic [31:0] d);
        @(negedge clk);
        fetch_valid = 1'b0;
        reg_sel = SEL_W'(sel);
        reg_wdata = d;
        reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        if (sel == 0) begin
            if (d[1]) m_en = d[0];
        end else if (sel <= N) begin
            m_cmp[sel-1] = d;
        end
    endtask

    task automatic do_read(input string req, input int sel);
        logic [31:0] e;
        @(negedge clk);
        reg_sel = SEL_W'(sel);
        #1;
        if (sel == 0) e = ctrl_exp();
        else if (sel <= N) e = m_cmp[sel-1];
        else e = '0;
        chk(req, reg_rdata, e);
    endtask

    task automatic do_fetch(input string req, input logic v, input logic [31:1] a);
        int ri;
        @(negedge clk);
        fetch_valid = v;
        fetch_addr = a;
        #1;
        ri = v ? exp_remap(a) : -1;
        chk({req, " brk"}, 32'(brk_req), v ? 32'(exp_brk(a)) : 32'd0);
        chk({req, " remap_hit"}, 32'(remap_hit), 32'(ri >= 0));
        if (ri >= 0) chk({req, " remap_idx"}, 32'(remap_idx), 32'(ri));
    endtask

    function automatic logic [31:1] haddr(logic [26:0] w, logic hw);
        return {3'b000, w, hw};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_en = 1'b0;
        for (int k = 0; k < N; k++) m_cmp[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_read("R1 ctrl", 0);
        for (int s = 1; s <= N; s++) do_read("R1 cmp", s);
        do_fetch("R1 idle", 1'b1, haddr(27'd0, 1'b0));

        // R3: count fields, writes cannot alter read-only fields
        do_read("R3 ctrl fields", 0);
        do_write(0, 32'hFFFF_FFFD);
        do_read("R2 keyless write ignored", 0);
        do_write(0, 32'hFFFF_FFFF);
        do_read("R3 ro fields after keyed write", 0);
        do_write(0, 32'h0000_0000);
        do_read("R2 keyless clear ignored", 0);

        // R4: readback and unmapped select
        do_write(1, 32'h5A5A_A5A5);
        do_read("R4 cmp readback", 1);
        do_write(N + 1, 32'hFFFF_FFFF);
        do_read("R4 unmapped reads zero", N + 1);
        for (int s = 1; s <= N; s++) do_read("R4 unmapped write no alias", s);

        // R6: halfword selection
        do_write(1, {2'b01, 1'b0, 27'h10, 2'b01});
        do_write(2, {2'b10, 1'b0, 27'h20, 2'b01});
        do_write(3, {2'b11, 1'b0, 27'h30, 2'b01});
        do_fetch("R6 lo match lo", 1'b1, haddr(27'h10, 1'b0));
        do_fetch("R6 lo match hi", 1'b1, haddr(27'h10, 1'b1));
        do_fetch("R6 hi match lo", 1'b1, haddr(27'h20, 1'b0));
        do_fetch("R6 hi match hi", 1'b1, haddr(27'h20, 1'b1));
        do_fetch("R6 both lo", 1'b1, haddr(27'h30, 1'b0));
        do_fetch("R6 both hi", 1'b1, haddr(27'h30, 1'b1));
        do_fetch("R5 no address match", 1'b1, haddr(27'h31, 1'b0));
        do_fetch("R5 fetch invalid", 1'b0, haddr(27'h30, 1'b0));

        // R7: remap priority, break comparator on same word
        do_write(4, {2'b11, 1'b0, 27'h40, 2'b01});
        do_write(5, {2'b00, 1'b0, 27'h40, 2'b01});
        do_write(6, {2'b00, 1'b0, 27'h40, 2'b01});
        do_fetch("R7 lowest remap", 1'b1, haddr(27'h40, 1'b1));
        do_write(5, {2'b00, 1'b0, 27'h40, 2'b00});
        do_fetch("R8 disabled comparator skipped", 1'b1, haddr(27'h40, 1'b0));

        // R9: high region
        do_fetch("R9 high region", 1'b1, {3'b001, 27'h30, 1'b0});
        do_fetch("R9 high region remap", 1'b1, {3'b100, 27'h40, 1'b0});

        // R8: global enable cleared
        do_write(0, 32'h0000_0002);
        do_fetch("R8 global off brk", 1'b1, haddr(27'h30, 1'b0));
        do_fetch("R8 global off remap", 1'b1, haddr(27'h40, 1'b0));
        do_write(0, 32'h0000_0003);

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 2) begin
                int s = int'($urandom_range(0, N + 1));
                logic [31:0] d = $urandom;
                if (s != 0) begin
                    d[28:2] = 27'($urandom_range(0, 3));
                    d[0] = ($urandom_range(0, 3) != 0);
                end else if ($urandom_range(0, 3) != 0) begin
                    d[0] = 1'b1;
                end
                do_write(s, d);
            end else if (op < 3) begin
                do_read("R3 R4 random read", int'($urandom_range(0, N + 1)));
            end else begin
                logic [31:1] a;
                a = haddr(27'($urandom_range(0, 4)), 1'($urandom));
                if ($urandom_range(0, 9) == 0) a[31:29] = 3'($urandom_range(1, 7));
                do_fetch("R5 R6 R7 random fetch", ($urandom_range(0, 7) != 0), a);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule